// File: doc/BRIEF.md
# Latched-Input DAC Write Controller

This block sits between a sample source and an 8-bit converter whose input register is loaded by an active-low latch strobe. A sample word is offered with a valid strobe. It is taken only when the block reports ready. A mode input selects whether the word is plain unsigned or signed two's complement. A signed word is recoded to offset binary so that the converter spans a bipolar range.

Each accepted word goes onto the converter data bus at once. The bus then settles for a set number of clocks before the latch strobe goes low. The strobe stays low for a set width and rises again. The bus is held after the strobe rises. The block then waits out the converter's analog settling time before it reports ready again. Every pin toward the converter comes straight from a flip-flop, so no pin can glitch.

Top module: `dac_wr_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, ready is 1, the latch strobe is 1 (inactive) and the data bus is 0.
- R2: A word is accepted on a rising clock edge where in_valid and ready are both 1. From that edge on, ready is 0 and the bus carries the encoded word.
- R3: With in_signed = 0 the bus value equals the input word unchanged.
- R4: With in_signed = 1 the bus value is the input word with bit 7 inverted. This is the offset binary code, equal to the signed value plus 128.
- R5: After the accepting edge the strobe stays high for exactly SETUP_CYC cycles before it falls.
- R6: The strobe stays low for exactly STROBE_CYC cycles per write and goes low once per write.
- R7: The bus value does not change from the accepting edge until the next accepting edge. This covers the setup, the strobe, the HOLD_CYC hold cycles and the settling wait.
- R8: ready returns to 1 exactly SETUP_CYC+STROBE_CYC+HOLD_CYC+SETTLE_CYC cycles after the accepting edge, with the strobe high.
- R9: in_valid while ready is 0 is ignored: bus, strobe and ready timing are unchanged. With in_valid at 0 nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample word offered |
| in_data | input | 8 | Sample word |
| in_signed | input | 1 | 1: word is two's complement, recode to offset binary |
| ready | output | 1 | Block can take a word |
| dac_data | output | 8 | Converter data bus (registered) |
| dac_le_n | output | 1 | Converter latch strobe, active low (registered) |

## Verification
The bench takes the accepting edge as cycle 0 and samples on the falling edge after each later clock. In that timeline the bus and a low ready are due at cycle 0. The strobe is low from cycle SETUP_CYC up to but not including cycle SETUP_CYC+STROBE_CYC. ready returns at cycle SETUP_CYC+STROBE_CYC+HOLD_CYC+SETTLE_CYC. Every write of all 256 words in both modes is traced cycle by cycle over that whole window against the expected value of each output. Some writes hold a competing request active through the busy window, to show that it is ignored.

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl #(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int SETTLE_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_signed,
  output logic              ready,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_le_n
);
  localparam int M1   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int M2   = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 2);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_SETTLE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          take;
  logic [DATA_W-1:0] enc;

  assign take = in_valid && ready;
  assign enc  = in_signed ? {~in_data[DATA_W-1], in_data[DATA_W-2:0]} : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ready    <= 1'b1;
      dac_le_n <= 1'b1;
      dac_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          dac_data <= enc;
          ready    <= 1'b0;
          st       <= S_SETUP;
          cnt      <= CW'(SETUP_CYC - 1);
        end
        S_SETUP: if (cnt == '0) begin
          dac_le_n <= 1'b0;
          st       <= S_STRB;
          cnt      <= CW'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_STRB: if (cnt == '0) begin
          dac_le_n <= 1'b1;
          st       <= S_HOLD;
          cnt      <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt == '0) begin
          st  <= S_SETTLE;
          cnt <= CW'(SETTLE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_SETTLE: if (cnt == '0) begin
          st    <= S_IDLE;
          ready <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] lo_len, since_acc;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len    <= '0;
      since_acc <= '1;
    end else begin
      lo_len    <= dac_le_n ? '0 : lo_len + 1'b1;
      since_acc <= take ? '0 : ((since_acc == '1) ? since_acc : since_acc + 1'b1);
    end
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ready);
  // R7
  bus_stable_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(dac_data));
  // R7
  bus_stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_le_n) |-> $stable(dac_data));
  // R5
  setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_le_n) |-> (since_acc == CW'(SETUP_CYC)));
  // R6
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_le_n) |-> (lo_len == CW'(STROBE_CYC)));
  // R6
  strobe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_le_n |-> !ready);
  // R8
  ready_back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> dac_le_n);
endmodule

// File: tb/dac_wr_ctrl_tb.sv
module dac_wr_ctrl_tb;
  localparam int S = 2, P = 2, H = 1, W = 6;
  localparam int BUSY = S + P + H + W;

  logic clk = 0, rst_n = 0, in_valid = 0, in_signed = 0;
  logic [7:0] in_data = 0;
  logic ready, dac_le_n;
  logic [7:0] dac_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_wr_ctrl #(.DATA_W(8), .SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H), .SETTLE_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_signed(in_signed),
    .ready(ready), .dac_data(dac_data), .dac_le_n(dac_le_n));

  function automatic logic [7:0] expect_code(input logic [7:0] d, input logic sg);
    int v;
    v = sg ? (int'($signed(d)) + 128) : int'(d);
    return 8'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic sg, input bit intrude);
    logic [7:0] e;
    bit ok_le, ok_dat, ok_rdy;
    int bad_le, bad_dat, bad_rdy;
    e = expect_code(d, sg);
    ok_le = 1; ok_dat = 1; ok_rdy = 1; bad_le = 0; bad_dat = 0; bad_rdy = 0;
    in_valid = 1; in_data = d; in_signed = sg;
    @(posedge clk);
    for (int j = 0; j <= BUSY; j++) begin
      @(negedge clk);
      if (dac_le_n !== ((j >= S && j < S + P) ? 1'b0 : 1'b1)) begin ok_le = 0; bad_le = j; end
      if (dac_data !== e) begin ok_dat = 0; bad_dat = dac_data; end
      if (ready !== (j >= BUSY)) begin ok_rdy = 0; bad_rdy = j; end
      if (intrude && j < BUSY) begin
        in_valid = 1; in_data = ~d; in_signed = ~sg;
      end else begin
        in_valid = 0;
      end
    end
    chk(ok_le, "R5/R6 strobe shape", bad_le, S);
    chk(ok_dat, sg ? "R4/R7 offset binary bus" : "R3/R7 unsigned bus", bad_dat, e);
    chk(ok_rdy, "R8 ready timing", bad_rdy, BUSY);
    if (intrude) chk(ok_dat && ok_rdy && ok_le, "R9 busy request ignored", dac_data, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready === 1 && dac_le_n === 1 && dac_data === 0, "R1 reset state", {ready, dac_le_n, dac_data}, 10'h300);
    rst_n = 1;
    @(negedge clk);
    chk(ready === 1 && dac_le_n === 1 && dac_data === 0, "R1 after reset", {ready, dac_le_n, dac_data}, 10'h300);
    in_data = 8'h5A;
    repeat (4) @(negedge clk);
    chk(ready === 1 && dac_le_n === 1 && dac_data === 0, "R9 idle valid low", {ready, dac_le_n, dac_data}, 10'h300);
    do_write(8'h00, 1'b0, 1'b0);
    chk(dac_data === 8'h00, "R2 first word accepted", dac_data, 0);
    for (int sg = 0; sg < 2; sg++)
      for (int d = 0; d < 256; d++)
        do_write(8'(d), sg[0], (d % 7) == 3);
    do_write(8'h80, 1'b1, 1'b0);
    chk(dac_data === 8'h00, "R4 most negative maps to 0", dac_data, 0);
    do_write(8'h7F, 1'b1, 1'b1);
    chk(dac_data === 8'hFF, "R4 most positive maps to FF", dac_data, 8'hFF);
    repeat (5) @(negedge clk);
    chk(dac_data === 8'hFF && dac_le_n === 1 && ready === 1, "R9 no change while idle", dac_data, 8'hFF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule